// File: doc/BRIEF.md
# Four-Entry Instruction Address Translator With Recency Tracking

This block translates instruction fetch addresses for a processor core. It holds four fully associative page entries and tracks how recently each was used with a 6-bit pairwise-order field. A fetch is accepted when `fetch_ready` is high. One cycle later the block returns a physical address, the entry that supplied it and a fault code. The fault code reports an address error, a miss, a protection fault or a multiple match.

Some fetches need no translation. These are privileged fetches into the direct-mapped window and all fetches while translation is off. They pass straight through with the upper three address bits cleared.

When no entry matches, the block raises a request to a larger unified translation table that sits outside it. The request carries the fetch address, the ASID and an "ignore ASID" flag, and the block stalls until the grant arrives. If the unified table reports a single hit, the block copies the returned page into the least recently used slot and answers the fetch from that slot.

Top module: `fetch_itlb`

## Requirements
- R1: After reset, `fetch_ready` is 1, `rsp_valid` and `ut_req` are 0, all four entries are invalid (the first translated fetch misses), and the recency field is 0.
- R2: A privileged fetch in 0xE0000000..0xFFFFFEFF, or a user fetch with bit 31 set, gets fault code 1 (address error) in the cycle after acceptance.
- R3: A privileged fetch in 0x80000000..0xBFFFFFFF, or any fetch not caught by R2 while `xlat_on` is 0, returns fault 0, `rsp_mapped` 0, and a physical address equal to the fetch address with bits 31:29 cleared. A privileged fetch at 0xFFFFFF00 or above is treated like an ordinary address.
- R4: A single matching entry produces, one cycle after acceptance, fault 0, `rsp_mapped` 1, that entry's index and attributes, and a physical address. Page size comes from attribute bits {7,4}: 00 is 1 KB, 01 is 4 KB, 10 is 64 KB and 11 is 1 MB. The physical address takes the page bits from the stored physical page and the offset bits from the fetch address.
- R5: An entry matches when its valid bit (attribute bit 8) is set, its page bits are equal to the fetch address, and its ASID condition holds. The ASID condition is met when its share bit (attribute bit 1) is set, its ASID equals `fetch_asid`, or the fetch is privileged with `asid_bypass` set.
- R6: A single hit or a refill of entry n updates the recency field as follows. Entry 0 clears bits 5:3. Entry 1 sets bit 5 and clears bits 2:1. Entry 2 sets bits 4 and 2 and clears bit 0. Entry 3 sets bits 3, 1 and 0.
- R7: The refill slot is chosen in this priority order. It is entry 0 if recency bits 5:3 are all 1. Otherwise it is entry 1 if (field AND 0x26) = 0x06. Otherwise it is entry 2 if (field AND 0x15) = 0x01. Otherwise it is entry 3.
- R8: On a miss, `fetch_ready` drops and no response is given. `ut_req` is held with a stable `ut_va`, `ut_asid` and `ut_asid_ign` (privileged AND bypass) until `ut_gnt`.
- R9: When `ut_gnt` arrives with `ut_status` = 0 (hit), the block writes the returned page into the chosen slot. The stored attributes are the returned flags with bits 5, 2 and 0 cleared and bit 8 set. The response follows in the next cycle.
- R10: `ut_status` 1 (miss) gives fault 2 and `ut_status` 2 (multiple match) gives fault 4. In both cases nothing is written and the recency field is unchanged.
- R11: A fetch that matches more than one local entry gets fault 4, and the recency field is unchanged.
- R12: A user fetch served by an entry whose attribute bit 6 (user access) is clear gets fault 3. This applies to a hit and to a refill, and the recency update and the refill write still take place.
- R13: On any fault response, `rsp_pa`, `rsp_entry`, `rsp_mapped` and `rsp_attr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_valid | input | 1 | Fetch address presented |
| fetch_ready | output | 1 | Block can accept a fetch |
| fetch_va | input | 32 | Fetch virtual address |
| fetch_priv | input | 1 | Fetch is in privileged mode |
| fetch_asid | input | ASID_W | Current address-space identifier |
| xlat_on | input | 1 | Address translation enabled |
| asid_bypass | input | 1 | Ignore ASID for privileged fetches |
| rsp_valid | output | 1 | Response strobe |
| rsp_pa | output | 32 | Physical address |
| rsp_entry | output | 2 | Entry that supplied the translation |
| rsp_mapped | output | 1 | Response came from an entry |
| rsp_attr | output | 9 | Attributes of that entry |
| rsp_fault | output | 3 | 0 none, 1 address error, 2 miss, 3 protection, 4 multiple match |
| ut_req | output | 1 | Refill request to the unified table |
| ut_va | output | 32 | Address to look up |
| ut_asid | output | ASID_W | ASID to match |
| ut_asid_ign | output | 1 | Lookup should ignore ASID |
| ut_gnt | input | 1 | Unified-table answer is valid |
| ut_status | input | 2 | 0 hit, 1 miss, 2 multiple match |
| ut_vpn | input | 22 | Returned virtual page (address bits 31:10) |
| ut_ent_asid | input | ASID_W | Returned ASID |
| ut_ppn | input | PPN_W | Returned physical page (address bits from 10 up) |
| ut_flags | input | 9 | Returned attribute flags |

## Verification
The bench builds the block with its defaults: an 8-bit ASID and a 19-bit physical page. With these values, ASID mismatches and the share override can be reached with small distinct ASIDs, and all four page sizes fit into a 29-bit physical space. The bench chains refills so that the recency field walks every victim in turn. It then places a 1 MB page over a 4 KB page to produce a local multiple match, and checks that the next victim shows the recency field was left alone. Grant delays of zero to three cycles cover the stall path.

// File: rtl/fetch_itlb.sv
module fetch_itlb #(
  parameter int ASID_W = 8,
  parameter int PPN_W  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [31:0]       fetch_va,
  input  logic              fetch_priv,
  input  logic [ASID_W-1:0] fetch_asid,
  input  logic              xlat_on,
  input  logic              asid_bypass,
  output logic              rsp_valid,
  output logic [31:0]       rsp_pa,
  output logic [1:0]        rsp_entry,
  output logic              rsp_mapped,
  output logic [8:0]        rsp_attr,
  output logic [2:0]        rsp_fault,
  output logic              ut_req,
  output logic [31:0]       ut_va,
  output logic [ASID_W-1:0] ut_asid,
  output logic              ut_asid_ign,
  input  logic              ut_gnt,
  input  logic [1:0]        ut_status,
  input  logic [21:0]       ut_vpn,
  input  logic [ASID_W-1:0] ut_ent_asid,
  input  logic [PPN_W-1:0]  ut_ppn,
  input  logic [8:0]        ut_flags
);
  localparam int NENT  = 4;
  localparam int VPN_W = 22;

  localparam logic [2:0] F_NONE = 3'd0, F_ADDR = 3'd1, F_MISS = 3'd2,
                         F_PROT = 3'd3, F_MULTI = 3'd4;

  typedef enum logic {S_IDLE, S_FILL} st_t;

  function automatic logic [VPN_W-1:0] pmask(input logic [8:0] f);
    case ({f[7], f[4]})
      2'b00:   return 22'h3FFFFF;
      2'b01:   return 22'h3FFFFC;
      2'b10:   return 22'h3FFFC0;
      default: return 22'h3FFC00;
    endcase
  endfunction

  function automatic logic [31:0] xlate(input logic [31:0] va,
                                        input logic [PPN_W-1:0] ppn,
                                        input logic [8:0] f);
    logic [VPN_W-1:0] m, pg;
    m  = pmask(f);
    pg = (VPN_W'(ppn) & m) | (va[31:10] & ~m);
    return {pg, va[9:0]};
  endfunction

  function automatic logic [5:0] touch(input logic [5:0] r, input logic [1:0] n);
    case (n)
      2'd0:    return r & 6'h07;
      2'd1:    return (r & 6'h19) | 6'h20;
      2'd2:    return (r & 6'h3E) | 6'h14;
      default: return r | 6'h0B;
    endcase
  endfunction

  st_t               st;
  logic [5:0]        lru;
  logic [VPN_W-1:0]  e_vpn  [NENT];
  logic [ASID_W-1:0] e_asid [NENT];
  logic [PPN_W-1:0]  e_ppn  [NENT];
  logic [8:0]        e_flg  [NENT];

  logic [31:0]       q_va;
  logic              q_priv;
  logic [ASID_W-1:0] q_asid;
  logic              q_ign;

  logic [NENT-1:0]   hit;
  logic [1:0]        hidx, vic;
  logic              multi, ign, addr_err, pass;

  assign ign = fetch_priv & asid_bypass;

  for (genvar g = 0; g < NENT; g++) begin : g_cmp
    assign hit[g] = e_flg[g][8]
                  & (e_flg[g][1] | ign | (e_asid[g] == fetch_asid))
                  & (((e_vpn[g] ^ fetch_va[31:10]) & pmask(e_flg[g])) == '0);
  end

  always_comb begin
    hidx = '0;
    for (int i = 0; i < NENT; i++)
      if (hit[i]) hidx = 2'(i);
  end

  assign multi = (hit & (hit - 4'd1)) != '0;

  always_comb begin
    if (lru[5:3] == 3'b111)            vic = 2'd0;
    else if ((lru & 6'h26) == 6'h06)   vic = 2'd1;
    else if ((lru & 6'h15) == 6'h01)   vic = 2'd2;
    else                               vic = 2'd3;
  end

  assign addr_err = fetch_priv ? (fetch_va[31:29] == 3'b111 && fetch_va[31:8] != 24'hFFFFFF)
                               : fetch_va[31];
  assign pass     = (fetch_priv & fetch_va[31:30] == 2'b10) | ~xlat_on;

  assign fetch_ready = (st == S_IDLE);
  assign ut_req      = (st == S_FILL);
  assign ut_va       = q_va;
  assign ut_asid     = q_asid;
  assign ut_asid_ign = q_ign;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      lru        <= '0;
      q_va       <= '0;
      q_priv     <= 1'b0;
      q_asid     <= '0;
      q_ign      <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_pa     <= '0;
      rsp_entry  <= '0;
      rsp_mapped <= 1'b0;
      rsp_attr   <= '0;
      rsp_fault  <= F_NONE;
      for (int i = 0; i < NENT; i++) begin
        e_vpn[i]  <= '0;
        e_asid[i] <= '0;
        e_ppn[i]  <= '0;
        e_flg[i]  <= '0;
      end
    end else begin
      rsp_valid  <= 1'b0;
      rsp_pa     <= '0;
      rsp_entry  <= '0;
      rsp_mapped <= 1'b0;
      rsp_attr   <= '0;
      rsp_fault  <= F_NONE;
      case (st)
        S_IDLE: if (fetch_valid) begin
          if (addr_err) begin
            rsp_valid <= 1'b1;
            rsp_fault <= F_ADDR;
          end else if (pass) begin
            rsp_valid <= 1'b1;
            rsp_pa    <= {3'b000, fetch_va[28:0]};
          end else if (multi) begin
            rsp_valid <= 1'b1;
            rsp_fault <= F_MULTI;
          end else if (|hit) begin
            rsp_valid <= 1'b1;
            lru       <= touch(lru, hidx);
            if (!fetch_priv && !e_flg[hidx][6]) begin
              rsp_fault <= F_PROT;
            end else begin
              rsp_pa     <= xlate(fetch_va, e_ppn[hidx], e_flg[hidx]);
              rsp_entry  <= hidx;
              rsp_mapped <= 1'b1;
              rsp_attr   <= e_flg[hidx];
            end
          end else begin
            st     <= S_FILL;
            q_va   <= fetch_va;
            q_priv <= fetch_priv;
            q_asid <= fetch_asid;
            q_ign  <= ign;
          end
        end
        S_FILL: if (ut_gnt) begin
          st        <= S_IDLE;
          rsp_valid <= 1'b1;
          case (ut_status)
            2'd0: begin
              e_vpn[vic]  <= ut_vpn;
              e_asid[vic] <= ut_ent_asid;
              e_ppn[vic]  <= ut_ppn;
              e_flg[vic]  <= (ut_flags & 9'h0DA) | 9'h100;
              lru         <= touch(lru, vic);
              if (!q_priv && !ut_flags[6]) begin
                rsp_fault <= F_PROT;
              end else begin
                rsp_pa     <= xlate(q_va, ut_ppn, ut_flags);
                rsp_entry  <= vic;
                rsp_mapped <= 1'b1;
                rsp_attr   <= (ut_flags & 9'h0DA) | 9'h100;
              end
            end
            2'd2:    rsp_fault <= F_MULTI;
            default: rsp_fault <= F_MISS;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fetch_itlb_chk.sv
module fetch_itlb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_valid,
  input logic        fetch_ready,
  input logic [31:0] fetch_va,
  input logic        fetch_priv,
  input logic        xlat_on,
  input logic        rsp_valid,
  input logic [31:0] rsp_pa,
  input logic        rsp_mapped,
  input logic [8:0]  rsp_attr,
  input logic [2:0]  rsp_fault,
  input logic        ut_req,
  input logic [31:0] ut_va,
  input logic        ut_gnt
);
  p_user_hi_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready && !fetch_priv && fetch_va[31]
    |=> rsp_valid && rsp_fault == 3'd1);

  p_priv_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready && fetch_priv && fetch_va[31:30] == 2'b10
    |=> rsp_valid && rsp_fault == 3'd0 && !rsp_mapped
        && rsp_pa == {3'b000, $past(fetch_va[28:0])});

  p_at_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready && !xlat_on && !fetch_va[31]
    |=> rsp_valid && rsp_fault == 3'd0 && !rsp_mapped);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ut_req && !ut_gnt |=> ut_req && $stable(ut_va));

  p_fill_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ut_req |-> !rsp_valid);

  p_grant_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ut_req && ut_gnt |=> rsp_valid && fetch_ready);

  p_attr_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_mapped
    |-> rsp_attr[8] && !rsp_attr[5] && !rsp_attr[2] && !rsp_attr[0]);

  p_fault_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 3'd0
    |-> !rsp_mapped && rsp_pa == 32'd0 && rsp_attr == 9'd0);
endmodule

bind fetch_itlb fetch_itlb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
  .fetch_va(fetch_va), .fetch_priv(fetch_priv), .xlat_on(xlat_on),
  .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_mapped(rsp_mapped),
  .rsp_attr(rsp_attr), .rsp_fault(rsp_fault), .ut_req(ut_req),
  .ut_va(ut_va), .ut_gnt(ut_gnt)
);

// File: tb/tb_fetch_itlb.sv
`timescale 1ns/1ps
module tb_fetch_itlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [31:0] fetch_va = '0;
  logic        fetch_priv = 1'b0;
  logic [7:0]  fetch_asid = '0;
  logic        xlat_on = 1'b0;
  logic        asid_bypass = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_entry;
  logic        rsp_mapped;
  logic [8:0]  rsp_attr;
  logic [2:0]  rsp_fault;
  logic        ut_req;
  logic [31:0] ut_va;
  logic [7:0]  ut_asid;
  logic        ut_asid_ign;
  logic        ut_gnt = 1'b0;
  logic [1:0]  ut_status = '0;
  logic [21:0] ut_vpn = '0;
  logic [7:0]  ut_ent_asid = '0;
  logic [18:0] ut_ppn = '0;
  logic [8:0]  ut_flags = '0;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  fetch_itlb dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_va(fetch_va), .fetch_priv(fetch_priv), .fetch_asid(fetch_asid),
    .xlat_on(xlat_on), .asid_bypass(asid_bypass), .rsp_valid(rsp_valid),
    .rsp_pa(rsp_pa), .rsp_entry(rsp_entry), .rsp_mapped(rsp_mapped),
    .rsp_attr(rsp_attr), .rsp_fault(rsp_fault), .ut_req(ut_req), .ut_va(ut_va),
    .ut_asid(ut_asid), .ut_asid_ign(ut_asid_ign), .ut_gnt(ut_gnt),
    .ut_status(ut_status), .ut_vpn(ut_vpn), .ut_ent_asid(ut_ent_asid),
    .ut_ppn(ut_ppn), .ut_flags(ut_flags)
  );

  // behavioural reference state
  bit [31:0] m_vpn [4];
  bit [31:0] m_asid[4];
  bit [31:0] m_ppn [4];
  bit [31:0] m_flg [4];
  bit [31:0] m_lru;

  bit [31:0] e_pa, e_attr;
  int        e_fault, e_ent;
  bit        e_map, e_miss;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit [31:0] amask(input bit [31:0] f);
    case ({f[7], f[4]})
      2'b00:   return 32'hFFFFFC00;
      2'b01:   return 32'hFFFFF000;
      2'b10:   return 32'hFFFF0000;
      default: return 32'hFFF00000;
    endcase
  endfunction

  task automatic touch(input int k);
    if (k == 0)      m_lru = m_lru & 32'h07;
    else if (k == 1) m_lru = (m_lru & 32'h19) | 32'h20;
    else if (k == 2) m_lru = (m_lru & 32'h3E) | 32'h14;
    else             m_lru = m_lru | 32'h0B;
  endtask

  task automatic serve(input int k, input bit [31:0] va, input bit pr);
    bit [31:0] m;
    if (!pr && !m_flg[k][6]) e_fault = 3;
    else begin
      m      = amask(m_flg[k]);
      e_pa   = (m_ppn[k] & m) | (va & ~m);
      e_ent  = k;
      e_map  = 1'b1;
      e_attr = m_flg[k];
    end
  endtask

  task automatic fetch(input bit [31:0] va, input bit pr, input bit [7:0] asid,
                       input bit at, input bit sv, input int dly,
                       input bit [1:0] ust, input bit [31:0] uvpn, input bit [7:0] uasid,
                       input bit [31:0] uppn, input bit [8:0] uflg, input string req);
    int n, k;
    e_pa = 0; e_attr = 0; e_fault = 0; e_ent = 0; e_map = 0; e_miss = 0;
    n = 0; k = 0;
    if (pr ? (va >= 32'hE0000000 && va < 32'hFFFFFF00) : va[31]) e_fault = 1;
    else if ((pr && va >= 32'h80000000 && va < 32'hC0000000) || !at) e_pa = va & 32'h1FFFFFFF;
    else begin
      for (int i = 0; i < 4; i++)
        if (m_flg[i][8] && (m_flg[i][1] || (pr && sv) || m_asid[i] == 32'(asid))
            && ((m_vpn[i] ^ va) & amask(m_flg[i])) == 0) begin
          n++; k = i;
        end
      if (n > 1) e_fault = 4;
      else if (n == 1) begin touch(k); serve(k, va, pr); end
      else begin
        e_miss = 1'b1;
        if (ust == 2'd0) begin
          if ((m_lru & 32'h38) == 32'h38)      k = 0;
          else if ((m_lru & 32'h26) == 32'h06) k = 1;
          else if ((m_lru & 32'h15) == 32'h01) k = 2;
          else                                 k = 3;
          m_vpn[k]  = uvpn & 32'hFFFFFC00;
          m_asid[k] = 32'(uasid);
          m_ppn[k]  = uppn & 32'h1FFFFC00;
          m_flg[k]  = (32'(uflg) & 32'h0DA) | 32'h100;
          touch(k);
          serve(k, va, pr);
        end else e_fault = (ust == 2'd2) ? 4 : 2;
      end
    end

    @(negedge clk);
    chk(fetch_ready == 1'b1, "R8", "ready before fetch", 32'(fetch_ready), 1);
    chk(rsp_valid == 1'b0, req, "idle rsp_valid", 32'(rsp_valid), 0);
    fetch_valid = 1'b1; fetch_va = va; fetch_priv = pr; fetch_asid = asid;
    xlat_on = at; asid_bypass = sv;
    @(negedge clk);
    fetch_valid = 1'b0;
    if (e_miss) begin
      for (int i = 0; i < dly; i++) begin
        chk(ut_req == 1'b1 && fetch_ready == 1'b0 && rsp_valid == 1'b0, "R8",
            "stall", {ut_req, fetch_ready, rsp_valid}, 32'h4);
        @(negedge clk);
      end
      chk(ut_req == 1'b1, "R8", "ut_req", 32'(ut_req), 1);
      chk(ut_va == va, "R8", "ut_va", ut_va, va);
      chk(ut_asid == asid, "R8", "ut_asid", 32'(ut_asid), 32'(asid));
      chk(ut_asid_ign == (pr && sv), "R8", "ut_asid_ign", 32'(ut_asid_ign), 32'(pr && sv));
      ut_gnt = 1'b1; ut_status = ust; ut_vpn = uvpn[31:10]; ut_ent_asid = uasid;
      ut_ppn = uppn[28:10]; ut_flags = uflg;
      @(negedge clk);
      ut_gnt = 1'b0;
    end else begin
      chk(ut_req == 1'b0, "R8", "no request on local answer", 32'(ut_req), 0);
    end
    chk(rsp_valid == 1'b1, req, "rsp_valid", 32'(rsp_valid), 1);
    chk(rsp_fault == 3'(e_fault), req, "fault", 32'(rsp_fault), 32'(e_fault));
    chk(rsp_pa == e_pa, req, "pa", rsp_pa, e_pa);
    chk(rsp_entry == 2'(e_ent), req, "entry", 32'(rsp_entry), 32'(e_ent));
    chk(rsp_mapped == e_map, req, "mapped", 32'(rsp_mapped), 32'(e_map));
    chk(rsp_attr == 9'(e_attr), req, "attr", 32'(rsp_attr), e_attr);
    if (e_fault != 0) chk(rsp_pa == 0 && rsp_attr == 0, "R13", "fault clears", rsp_pa, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_vpn[i] = 0; m_asid[i] = 0; m_ppn[i] = 0; m_flg[i] = 0; end
    m_lru = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_ready == 1'b1 && rsp_valid == 1'b0 && ut_req == 1'b0, "R1", "reset outputs",
        {fetch_ready, rsp_valid, ut_req}, 32'h4);

    // R3 / R2 region handling
    fetch(32'h0C001234, 0, 8'd5, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    fetch(32'hA1234567, 1, 8'd5, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
    fetch(32'hFFFFFF10, 1, 8'd5, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    fetch(32'hE0000010, 1, 8'd5, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
    fetch(32'h80000000, 0, 8'd5, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
    fetch(32'hFFFFFEFC, 1, 8'd5, 0, 0, 0, 0, 0, 0, 0, 0, "R2");

    // R1 empty table misses; R7 first victim 3; R9 flag drop
    fetch(32'h00401ABC, 0, 8'd5, 1, 0, 2, 0, 32'h00401000, 8'd5, 32'h0C020000, 9'h17D, "R1 R9");
    fetch(32'h00401FF0, 0, 8'd5, 1, 0, 0, 0, 0, 0, 0, 0, "R4");
    // R12 refill of supervisor-only page, victim 2
    fetch(32'h008003F0, 0, 8'd5, 1, 0, 1, 0, 32'h00800000, 8'd5, 32'h0A000C00, 9'h108, "R12");
    fetch(32'h008003F0, 1, 8'd5, 1, 0, 0, 0, 0, 0, 0, 0, "R4");
    fetch(32'h008003F4, 0, 8'd5, 1, 0, 0, 0, 0, 0, 0, 0, "R12");
    // R5 shared 64K page, victim 1 via R6/R7
    fetch(32'h0100ABCD, 0, 8'd5, 1, 0, 3, 0, 32'h01000000, 8'd7, 32'h05430000, 9'h1C2, "R7");
    fetch(32'h0100F00C, 0, 8'd9, 1, 0, 0, 0, 0, 0, 0, 0, "R5");
    // R10 unified-table miss / multi, nothing written
    fetch(32'h00401000, 0, 8'd6, 1, 0, 0, 1, 0, 0, 0, 0, "R10");
    fetch(32'h00401000, 0, 8'd6, 1, 0, 2, 2, 0, 0, 0, 0, "R10");
    // R5 ASID bypass in privileged mode
    fetch(32'h00401004, 1, 8'd6, 1, 1, 0, 0, 0, 0, 0, 0, "R5");
    fetch(32'h00401008, 0, 8'd6, 1, 1, 0, 1, 0, 0, 0, 0, "R5");
    // R6 victim 0 gets a 1M page overlapping the 4K page
    fetch(32'h00402010, 1, 8'd6, 1, 0, 1, 0, 32'h00400000, 8'd6, 32'h0C000000, 9'h1D0, "R6");
    // R11 local multi-hit, recency untouched
    fetch(32'h00401020, 1, 8'd6, 1, 1, 0, 0, 0, 0, 0, 0, "R11");
    fetch(32'h02000040, 1, 8'd6, 1, 1, 1, 0, 32'h02000000, 8'd6, 32'h00100000, 9'h150, "R11");
    fetch(32'h03000040, 1, 8'd6, 1, 0, 0, 0, 32'h03000000, 8'd6, 32'h00200000, 9'h140, "R7");
    fetch(32'h02000044, 0, 8'd6, 1, 0, 0, 0, 0, 0, 0, 0, "R4");

    @(negedge clk);
    chk(rsp_valid == 1'b0 && fetch_ready == 1'b1, "R8", "quiet end",
        {rsp_valid, fetch_ready}, 32'h1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule